// File: doc/BRIEF.md
# Console Receive Register Port

This block is the processor-facing side of a console keyboard receiver. A serial front end delivers whole characters, or a break condition, through a valid/ready pair. The block holds the most recent character in a 16-bit data buffer, sets a ready flag in a 16-bit control/status register, and raises a level interrupt request when interrupts are enabled. A break loads a composite error code into the buffer and can request a processor halt when an external enable allows it.

Reading the data buffer is destructive. It hands back the held value and, in the same access, clears the ready flag, strips the error bits and drops the interrupt. A character that is not read is protected from being overwritten for a bounded hold time. The front end sees this as ready held low. The hold time is counted by a prescaled timer. Once it runs out, the next character replaces the unread one. A 32-bit counter of accepted characters can be read for diagnostics.

Top module: `con_rx_port`

## Requirements
- R1: After reset the control/status register, the data buffer and both counter halves read 0, irq_o and halt_req_o are low, and rx_ready_o is high.
- R2: Register select 0 is the control/status register: bit 7 is the ready flag, bit 6 the interrupt enable, and every other bit reads 0. Only bit 6 is writable. A write that sets bit 7 leaves the ready flag unchanged, and writes to select 1 do not change the buffer.
- R3: An accepted character sets the ready flag. If the interrupt enable is 1, irq_o rises in the cycle after acceptance and stays high until it is cleared. irq_o is never high unless both the ready flag and the enable are set.
- R4: A read of select 1 while the ready flag is set returns the held 16-bit value. After that access the ready flag is 0, bits 15:8 of the buffer are 0, the low byte is kept, and irq_o is low. A read while the flag is clear changes nothing.
- R5: Writing 0 to the enable drops irq_o in the next cycle. Writing 1 while the ready flag is set and the enable was 0 raises irq_o in the next cycle.
- R6: While the ready flag is set, rx_ready_o stays low until PRESCALE*HOLD_TICKS cycles after acceptance. After that it is high, and a new character overwrites the buffer.
- R7: An accepted break loads the buffer with 16'hA400 (bit 15 summary error, bit 13 framing, bit 10 break) and sets the ready flag.
- R8: When a break is accepted with halt_en_i high, halt_req_o is high for exactly the one cycle after acceptance. With halt_en_i low it stays low.
- R9: With mode_8bit_i low the stored character has bit 7 forced to 0. With it high all 8 bits are kept.
- R10: Every accepted character or break increments a 32-bit counter. Select 2 reads its low half and select 3 its high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select: 0 status, 1 data, 2 count low, 3 count high |
| rd_en_i | input | 1 | Read strobe; side effects occur at the clock edge |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data of the selected register |
| rx_valid_i | input | 1 | Front end has a character or break |
| rx_byte_i | input | 8 | Received character |
| rx_break_i | input | 1 | The offered item is a break |
| rx_ready_o | output | 1 | Block accepts the offered item this cycle |
| mode_8bit_i | input | 1 | 1 keeps 8 data bits, 0 keeps 7 |
| halt_en_i | input | 1 | Allows a break to request a halt |
| irq_o | output | 1 | Level interrupt request |
| halt_req_o | output | 1 | One-cycle halt request after a break |

## Verification
The bench builds the block with PRESCALE=4 and HOLD_TICKS=5, which shortens the hold window to 20 cycles. This puts both sides of the hold boundary within a few dozen cycles: the front end is seen blocked partway through the window and free after it, and then the overwrite is observed. With the default values the same window would span 25 million cycles. The count width stays at 32. This leaves the high half observable only at its reset value.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;
  localparam int REG_W = 16;
  localparam int CHR_W = 8;
  localparam int CNT_W = 2 * REG_W;

  localparam logic [1:0] SEL_CSR  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CNTL = 2'd2;
  localparam logic [1:0] SEL_CNTH = 2'd3;

  localparam int CSR_RDY_BIT = 7;
  localparam int CSR_IE_BIT  = 6;

  // error summary | framing | break
  localparam logic [REG_W-1:0] BREAK_CODE = 16'hA400;
endpackage

// File: rtl/con_rx_hold_timer.sv
module con_rx_hold_timer #(
  parameter int PRESCALE   = 50000,
  parameter int HOLD_TICKS = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TW = $clog2(HOLD_TICKS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [TW-1:0] TICK_END = TW'(HOLD_TICKS);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] tick_q;

  assign expired_o = (tick_q == TICK_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (restart_i || !run_i) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (!expired_o) begin
      if (pre_q == PRE_LAST) begin
        pre_q  <= '0;
        tick_q <= tick_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assert_tick_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q <= TICK_END);
endmodule

// File: rtl/con_rx_data_path.sv
module con_rx_data_path
  import con_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             brk_i,
  input  logic [CHR_W-1:0] byte_i,
  input  logic             mode_8bit_i,
  input  logic             halt_en_i,
  input  logic             data_rd_i,
  output logic             done_o,
  output logic [REG_W-1:0] buf_o,
  output logic [CNT_W-1:0] count_o,
  output logic             halt_o
);
  logic [CHR_W-1:0] chr;
  assign chr = mode_8bit_i ? byte_i : {1'b0, byte_i[CHR_W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      buf_o   <= '0;
      count_o <= '0;
      halt_o  <= 1'b0;
    end else begin
      halt_o <= 1'b0;
      if (accept_i) begin
        done_o  <= 1'b1;
        buf_o   <= brk_i ? BREAK_CODE : {{(REG_W-CHR_W){1'b0}}, chr};
        count_o <= count_o + 1'b1;
        halt_o  <= brk_i && halt_en_i;
      end else if (data_rd_i && done_o) begin
        done_o <= 1'b0;
        buf_o  <= {{(REG_W-CHR_W){1'b0}}, buf_o[CHR_W-1:0]};
      end
    end
  end

  assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && done_o && !accept_i) |=> (!done_o && buf_o[REG_W-1:CHR_W] == '0));
  assert_halt_with_break_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (buf_o == BREAK_CODE && done_o));
  assert_seven_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !brk_i && !mode_8bit_i) |=> !buf_o[CHR_W-1]);
  assert_count_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/con_rx_irq_ctl.sv
module con_rx_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csr_wr_i,
  input  logic wr_ie_i,
  input  logic accept_i,
  input  logic data_rd_i,
  input  logic done_i,
  output logic ie_o,
  output logic irq_o
);
  logic ie_eff;
  assign ie_eff = csr_wr_i ? wr_ie_i : ie_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (csr_wr_i) ie_o <= wr_ie_i;
      if (csr_wr_i && !wr_ie_i)                           irq_o <= 1'b0;
      else if (accept_i && ie_eff)                        irq_o <= 1'b1;
      else if (data_rd_i && done_i)                       irq_o <= 1'b0;
      else if (csr_wr_i && wr_ie_i && done_i && !ie_o)    irq_o <= 1'b1;
    end
  end

  assert_irq_qualified_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_i && ie_o));
  assert_ie_off_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && !wr_ie_i) |=> !irq_o);
endmodule

// File: rtl/con_rx_port.sv
module con_rx_port
  import con_rx_pkg::*;
#(
  parameter int PRESCALE   = 50000,
  parameter int HOLD_TICKS = 500
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  reg_sel_i,
  input  logic        rd_en_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_break_i,
  output logic        rx_ready_o,
  input  logic        mode_8bit_i,
  input  logic        halt_en_i,
  output logic        irq_o,
  output logic        halt_req_o
);
  logic             done, ie, expired, accept, csr_wr, data_rd;
  logic [REG_W-1:0] buf_q, csr_view;
  logic [CNT_W-1:0] count;

  assign rx_ready_o = !done || expired;
  assign accept     = rx_valid_i && rx_ready_o;
  assign csr_wr     = wr_en_i && (reg_sel_i == SEL_CSR);
  assign data_rd    = rd_en_i && (reg_sel_i == SEL_DATA);

  always_comb begin
    csr_view = '0;
    csr_view[CSR_RDY_BIT] = done;
    csr_view[CSR_IE_BIT]  = ie;
  end

  always_comb begin
    unique case (reg_sel_i)
      SEL_CSR:  rd_data_o = csr_view;
      SEL_DATA: rd_data_o = buf_q;
      SEL_CNTL: rd_data_o = count[REG_W-1:0];
      default:  rd_data_o = count[CNT_W-1:REG_W];
    endcase
  end

  con_rx_hold_timer #(.PRESCALE(PRESCALE), .HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk_i, .rst_ni, .run_i(done), .restart_i(accept), .expired_o(expired));

  con_rx_data_path u_data (
    .clk_i, .rst_ni, .accept_i(accept), .brk_i(rx_break_i), .byte_i(rx_byte_i),
    .mode_8bit_i, .halt_en_i, .data_rd_i(data_rd), .done_o(done), .buf_o(buf_q),
    .count_o(count), .halt_o(halt_req_o));

  con_rx_irq_ctl u_irq (
    .clk_i, .rst_ni, .csr_wr_i(csr_wr), .wr_ie_i(wr_data_i[CSR_IE_BIT]),
    .accept_i(accept), .data_rd_i(data_rd), .done_i(done), .ie_o(ie), .irq_o(irq_o));

  assert_hold_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !expired && rx_valid_i && !data_rd) |=> ($stable(buf_q) && $stable(count)));
  assert_accept_sets_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> done);
endmodule

// File: tb/con_rx_port_test.sv
module con_rx_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0, rd_data;
  logic        rx_valid = 1'b0, rx_break = 1'b0, rx_ready;
  logic [7:0]  rx_byte = '0;
  logic        mode8 = 1'b1, halt_en = 1'b0;
  logic        irq, halt_req;
  int          checks = 0, errors = 0;
  logic        finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  con_rx_port #(.PRESCALE(4), .HOLD_TICKS(5)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(reg_sel), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .rx_break_i(rx_break), .rx_ready_o(rx_ready), .mode_8bit_i(mode8), .halt_en_i(halt_en),
    .irq_o(irq), .halt_req_o(halt_req));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [15:0] val);
    reg_sel = sel; rd_en = 1'b1;
    #1 val = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [15:0] val);
    reg_sel = sel; wr_data = val; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic brk, output logic halt_seen);
    rx_byte = b; rx_break = brk; rx_valid = 1'b1;
    @(negedge clk);
    halt_seen = halt_req;
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    do_reset();
    reg_rd(0, v); check("R1 csr", v, 0);
    reg_rd(1, v); check("R1 data", v, 0);
    reg_rd(2, v); check("R1 cnt lo", v, 0);
    reg_rd(3, v); check("R1 cnt hi", v, 0);
    check("R1 irq", irq, 0);
    check("R1 halt", halt_req, 0);
    check("R1 ready", rx_ready, 1);
  endtask

  task automatic t_csr;
    logic [15:0] v;
    do_reset();
    reg_wr(0, 16'hFFFF); reg_rd(0, v);
    check("R2 only ie writable", v, 16'h0040);
    reg_wr(0, 16'h0000); reg_rd(0, v);
    check("R2 ie cleared", v, 16'h0000);
    reg_wr(1, 16'h1234); reg_rd(1, v);
    check("R2 data write ignored", v, 16'h0000);
  endtask

  task automatic t_modes;
    logic [15:0] v; logic h;
    do_reset();
    mode8 = 1'b1; send(8'hC1, 0, h);
    reg_rd(0, v); check("R3 ready flag set", v, 16'h0080);
    check("R3 no irq when disabled", irq, 0);
    reg_rd(1, v); check("R9 8-bit kept", v, 16'h00C1);
    mode8 = 1'b0; send(8'hC1, 0, h);
    reg_rd(1, v); check("R9 7-bit masked", v, 16'h0041);
    mode8 = 1'b1;
  endtask

  task automatic t_irq;
    logic [15:0] v; logic h;
    do_reset();
    reg_wr(0, 16'h0040);
    send(8'h55, 0, h);
    check("R3 irq on accept", irq, 1);
    reg_wr(0, 16'h0000);
    check("R5 ie off drops irq", irq, 0);
    reg_wr(0, 16'h0040);
    check("R5 ie on with ready raises irq", irq, 1);
    reg_wr(0, 16'h0040);
    check("R5 irq holds", irq, 1);
    reg_rd(1, v);
    check("R4 read value", v, 16'h0055);
    check("R4 irq dropped", irq, 0);
    reg_rd(0, v); check("R4 ready cleared", v, 16'h0040);
    reg_rd(1, v); check("R4 idle read same", v, 16'h0055);
    reg_wr(0, 16'h0000); reg_wr(0, 16'h0040);
    check("R5 no irq when not ready", irq, 0);
  endtask

  task automatic t_break;
    logic [15:0] v; logic h;
    do_reset();
    halt_en = 1'b1; send(8'h00, 1, h);
    check("R8 halt pulse", h, 1);
    idle(1); check("R8 halt one cycle", halt_req, 0);
    reg_rd(1, v); check("R7 break code", v, 16'hA400);
    reg_rd(1, v); check("R4 errors stripped", v, 16'h0000);
    halt_en = 1'b0; send(8'h00, 1, h);
    check("R8 no halt when disabled", h, 0);
    reg_rd(0, v); check("R7 ready after break", v, 16'h0080);
    reg_rd(2, v); check("R10 count incl breaks", v, 2);
    reg_rd(3, v); check("R10 count hi", v, 0);
  endtask

  task automatic t_hold;
    logic [15:0] v; logic h;
    do_reset();
    send(8'h41, 0, h);
    rx_byte = 8'h42; rx_valid = 1'b1;
    idle(9);
    check("R6 held off", rx_ready, 0);
    rx_valid = 1'b0;
    reg_rd(1, v); reg_rd(1, v);
    check("R6 buffer kept", v, 16'h0041);
    send(8'h43, 0, h);
    idle(10); check("R6 held mid window", rx_ready, 0);
    idle(14); check("R6 released", rx_ready, 1);
    send(8'h44, 0, h);
    reg_rd(1, v); check("R6 overwrite", v, 16'h0044);
    reg_rd(2, v); check("R10 count", v, 3);
  endtask

  initial begin
    t_reset();
    t_csr();
    t_modes();
    t_irq();
    t_break();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule